// File: doc/BRIEF.md
# Double-Buffered SPI Shift Engine

This block moves bytes over SPI as either the clock-driving master or the clocked slave. Only one clock arrangement is supported: SCK rests low, the outgoing bit changes on the rising edge, and the incoming bit is captured on the falling edge. Bytes go out most significant bit first, eight bits per frame. A one-byte holding stage sits in front of the shift register, so software can queue the next byte while the current one is still on the wire.

Software sees three strobes and two flags. The write strobe fills the holding stage. The status-read and data-read strobes together clear the receive flag. `tx_empty_o` shows that the holding stage can take a byte. `rx_full_o` shows that a completed frame is waiting in `rd_data_o`. In master mode, SCK comes from the bus clock through a divider. In slave mode, the incoming SCK is synchronised into the bus clock domain and its edges are detected there.

Top module: `spi_dbuf_engine`

## Requirements
- R1: A write taken while `tx_empty_o` is 1 drives `tx_empty_o` to 0 at the next clock edge. `tx_empty_o` returns to 1 only when the held byte moves into the shift register.
- R2: When the shifter is idle, in either mode, `tx_empty_o` is 1 again two clock edges after the write strobe is sampled. A second byte can then be written at once, so 16 bits are queued.
- R3: In master mode, a loaded byte is sent MSB first over 8 SCK periods of 2*CLK_DIV bus cycles each. `mosi_o` changes on the rising edge of SCK, `miso_i` is captured on the falling edge, and SCK is low whenever the master is idle.
- R4: In master mode, a byte queued during a frame starts at once. Its first rising SCK edge comes exactly CLK_DIV bus cycles after the last falling edge of the previous frame.
- R5: A slave that is in the middle of a frame does not take a newly written byte until its eighth falling edge. Until then, `tx_empty_o` stays 0.
- R6: If nothing was loaded since the last frame, the next frame sends what the shift register holds, which is the byte received in the previous frame.
- R7: After the eighth falling edge of a frame, `rd_data_o` holds the received byte and `rx_full_o` is 1.
- R8: `rx_full_o` is cleared only by a status-read strobe while it is 1, followed by a data-read strobe. A data read alone does not clear it. A status read made while it is 0 does not arm the clear.
- R9: A write made while `tx_empty_o` is 0 is ignored, and the byte already held is sent unchanged.
- R10: After reset, `tx_empty_o` is 1, `rx_full_o` is 0 and `sck_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 selects master, 0 selects slave; change it only while idle |
| wr_en_i | input | 1 | Write strobe for the holding stage |
| wr_data_i | input | DATA_W | Byte to transmit |
| status_rd_i | input | 1 | Status-read strobe (first step of the receive clear) |
| data_rd_i | input | 1 | Data-read strobe (second step of the receive clear) |
| rd_data_o | output | DATA_W | Last received byte |
| tx_empty_o | output | 1 | Holding stage can accept a byte |
| rx_full_o | output | 1 | Received byte waiting |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_i | input | 1 | Serial data in for master mode |

## Verification
The end of a frame and the hand-over from the holding stage can happen in the same clock cycle. The received byte is pushed into the receive register, and the queued byte replaces the shifter contents at that same edge. The bench provokes this by writing a second byte while the master is mid-frame, and by writing mid-frame in slave mode, including a rejected extra write. At the falling-edge sample that closes the frame, it checks that `rd_data_o` has the incoming byte, that `tx_empty_o` has risen, and that the next frame carries the queued byte after a gap of exactly CLK_DIV cycles.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;
endpackage

// File: rtl/spi_dbuf_sync.sv
module spi_dbuf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/spi_dbuf_txq.sv
module spi_dbuf_txq #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic              hold_vld_o,
  output logic [DATA_W-1:0] hold_data_o
);
  logic              full_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (wr_en_i && !full_q) begin
      hold_q <= wr_data_i;
      full_q <= 1'b1;
    end else if (load_i) begin
      full_q <= 1'b0;
    end
  end

  assign hold_vld_o  = full_q;
  assign hold_data_o = hold_q;

  AST_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_en_i) |=> (hold_q == $past(hold_q))); // R9
  AST_LOAD_FROM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> full_q); // R1
endmodule

// File: rtl/spi_dbuf_rxq.sv
module spi_dbuf_rxq #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              status_rd_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] rx_q;
  logic              full_q;
  logic              armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q    <= '0;
      full_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (push_i) begin
      rx_q    <= push_data_i;
      full_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (data_rd_i && armed_q) begin
      full_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (status_rd_i && full_q) begin
      armed_q <= 1'b1;
    end
  end

  assign rx_data_o = rx_q;
  assign full_o    = full_q;

  AST_RXF_CLEAR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_q) |-> $past(armed_q && data_rd_i)); // R8
  AST_RXF_ON_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (full_q && rx_q == $past(push_data_i))); // R7
endmodule

// File: rtl/spi_dbuf_shifter.sv
module spi_dbuf_shifter
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_DIV     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              hold_vld_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              load_o,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              sdo_o,
  input  logic              sdi_i,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  role_e             role;
  logic              is_mst;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] shift_nxt;
  logic [CNT_W-1:0]  bit_q;
  logic [DIV_W-1:0]  div_q;
  logic              active_q, sck_q, sdo_q, sck_d_q, sck_s;
  logic              m_tick, s_rise, s_fall, rise_ev, fall_ev, frame_end;

  spi_dbuf_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sck_i),
    .q_o   (sck_s)
  );

  assign role      = role_e'(master_i);
  assign is_mst    = (role == ROLE_MASTER);
  assign m_tick    = active_q && (div_q == DIV_LAST);
  assign s_rise    = sck_s && !sck_d_q;
  assign s_fall    = !sck_s && sck_d_q;
  assign rise_ev   = is_mst ? (m_tick && !sck_q) : s_rise;
  assign fall_ev   = is_mst ? (m_tick && sck_q) : (s_fall && active_q);
  assign frame_end = fall_ev && (bit_q == LAST_BIT);
  assign load_o    = hold_vld_i && (!active_q || frame_end);
  assign shift_nxt = {shreg_q[DATA_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      bit_q    <= '0;
      div_q    <= '0;
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      sdo_q    <= 1'b0;
      sck_d_q  <= 1'b0;
    end else begin
      sck_d_q <= sck_s;
      if (rise_ev)
        sdo_q <= (load_o && !active_q) ? hold_data_i[DATA_W-1] : shreg_q[DATA_W-1];
      if (is_mst) begin
        if (active_q) begin
          div_q <= m_tick ? '0 : div_q + DIV_W'(1);
          if (m_tick) sck_q <= !sck_q;
        end else if (load_o) begin
          active_q <= 1'b1;
          div_q    <= '0;
          sck_q    <= 1'b0;
        end
      end else begin
        sck_q <= 1'b0;
        div_q <= '0;
        if (rise_ev && !active_q) active_q <= 1'b1;
      end
      if (fall_ev) begin
        if (frame_end) begin
          bit_q    <= '0;
          shreg_q  <= load_o ? hold_data_i : shift_nxt;
          active_q <= is_mst && load_o;  // master chains straight into the next frame
        end else begin
          bit_q   <= bit_q + CNT_W'(1);
          shreg_q <= shift_nxt;
        end
      end else if (load_o) begin
        shreg_q <= hold_data_i;
      end
    end
  end

  assign push_o      = frame_end;
  assign push_data_o = shift_nxt;
  assign sck_o       = sck_q;
  assign sdo_o       = sdo_q;
  assign busy_o      = active_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mst && !active_q) |-> !sck_q); // R3
  AST_SLV_LOAD_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_mst && active_q && load_o) |-> (s_fall && bit_q == LAST_BIT)); // R5
  AST_MST_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mst && frame_end && hold_vld_i) |=> (active_q && !sck_q && div_q == '0)); // R4
endmodule

// File: rtl/spi_dbuf_engine.sv
module spi_dbuf_engine #(
  parameter int DATA_W      = 8,
  parameter int CLK_DIV     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              status_rd_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tx_empty_o,
  output logic              rx_full_o,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              mosi_o,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              miso_i
);
  logic              hold_vld, load, push, busy, sdo, sdi;
  logic [DATA_W-1:0] hold_data, push_data;

  assign sdi = master_i ? miso_i : mosi_i;

  spi_dbuf_txq #(.DATA_W(DATA_W)) u_txq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .load_i     (load),
    .hold_vld_o (hold_vld),
    .hold_data_o(hold_data)
  );

  spi_dbuf_shifter #(
    .DATA_W     (DATA_W),
    .CLK_DIV    (CLK_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .master_i   (master_i),
    .hold_vld_i (hold_vld),
    .hold_data_i(hold_data),
    .load_o     (load),
    .push_o     (push),
    .push_data_o(push_data),
    .sck_o      (sck_o),
    .sck_i      (sck_i),
    .sdo_o      (sdo),
    .sdi_i      (sdi),
    .busy_o     (busy)
  );

  spi_dbuf_rxq #(.DATA_W(DATA_W)) u_rxq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_data_i(push_data),
    .status_rd_i(status_rd_i),
    .data_rd_i  (data_rd_i),
    .rx_data_o  (rd_data_o),
    .full_o     (rx_full_o)
  );

  assign tx_empty_o = !hold_vld;
  assign mosi_o     = master_i ? sdo : 1'b0;
  assign miso_o     = master_i ? 1'b0 : sdo;

  AST_IDLE_TAKES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_vld && !busy) |=> !hold_vld); // R2
endmodule

// File: tb/tb_spi_dbuf_engine.sv
`timescale 1ns/1ps
module tb_spi_dbuf_engine;
  localparam int CLK_DIV = 2;
  localparam int HALF    = 6;

  logic       clk_i = 1'b0, rst_ni = 1'b0, master_i = 1'b1;
  logic       wr_en_i = 1'b0, status_rd_i = 1'b0, data_rd_i = 1'b0;
  logic [7:0] wr_data_i = '0, rd_data_o;
  logic       tx_empty_o, rx_full_o, sck_o, mosi_o, miso_o;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0;

  int n_chk = 0, n_err = 0, since_fall = 0, last_gap = 0;
  logic sck_prev = 1'b0;
  bit   done = 1'b0;

  always #2 clk_i = ~clk_i;

  spi_dbuf_engine #(.DATA_W(8), .CLK_DIV(CLK_DIV), .SYNC_STAGES(2)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .status_rd_i(status_rd_i), .data_rd_i(data_rd_i),
    .rd_data_o(rd_data_o), .tx_empty_o(tx_empty_o), .rx_full_o(rx_full_o),
    .sck_o(sck_o), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_i(miso_i)
  );

  task automatic tick(); @(negedge clk_i); endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] v);
    wr_en_i = 1'b1; wr_data_i = v; tick(); wr_en_i = 1'b0;
  endtask

  task automatic rd_status(); status_rd_i = 1'b1; tick(); status_rd_i = 1'b0; endtask
  task automatic rd_data();   data_rd_i   = 1'b1; tick(); data_rd_i   = 1'b0; endtask

  // acts as the far-end slave while the DUT is master
  task automatic mon_frame(input logic [7:0] mi, output logic [7:0] mo);
    int idx = 0;
    mo = '0;
    while (idx < 8) begin
      tick();
      since_fall++;
      if (sck_o && !sck_prev) begin
        last_gap    = since_fall;
        mo[7 - idx] = mosi_o;
        miso_i      = mi[7 - idx];
      end else if (!sck_o && sck_prev) begin
        since_fall = 0;
        idx++;
      end
      sck_prev = sck_o;
    end
  endtask

  // acts as the far-end master while the DUT is slave
  task automatic slave_frame(input logic [7:0] mi, input int wr_bit, input logic [7:0] w1,
                             input logic [7:0] w2, output logic [7:0] so, output logic txe_late);
    so = '0; txe_late = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sck_i = 1'b1; mosi_i = mi[7 - i];
      repeat (HALF) tick();
      if (i == wr_bit) begin write_byte(w1); write_byte(w2); end
      if (i == 7) txe_late = tx_empty_o;
      so[7 - i] = miso_o;
      sck_i = 1'b0;
      repeat (HALF) tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] mo, so;
    logic       txe;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk("R10 tx_empty", int'(tx_empty_o), 1);
    chk("R10 rx_full", int'(rx_full_o), 0);
    chk("R10 sck", int'(sck_o), 0);

    // master: two bytes queued back to back
    write_byte(8'hC3);
    chk("R1 tx_empty after write", int'(tx_empty_o), 0);
    tick();
    chk("R2 master idle reload", int'(tx_empty_o), 1);
    write_byte(8'h5E);
    chk("R1 second write queued", int'(tx_empty_o), 0);
    mon_frame(8'h96, mo);
    chk("R3 master byte1", int'(mo), 'hC3);
    chk("R1 load at frame end", int'(tx_empty_o), 1);
    chk("R7 rx byte1", int'(rd_data_o), 'h96);
    chk("R7 rx_full byte1", int'(rx_full_o), 1);
    mon_frame(8'h3B, mo);
    chk("R4 gap", last_gap, CLK_DIV);
    chk("R3 master byte2", int'(mo), 'h5E);
    chk("R7 rx byte2", int'(rd_data_o), 'h3B);
    repeat (4) tick();
    chk("R3 sck idle low", int'(sck_o), 0);
    rd_status(); rd_data();
    chk("R8 cleared", int'(rx_full_o), 0);

    // master sweep over every byte value
    for (int v = 0; v < 256; v++) begin
      write_byte(8'(v));
      mon_frame(8'(v) ^ 8'hA5, mo);
      chk("R3 sweep mosi", int'(mo), v);
      chk("R7 sweep rx", int'(rd_data_o), (v ^ 'hA5) & 'hFF);
      rd_status(); rd_data();
      chk("R8 sweep clear", int'(rx_full_o), 0);
    end

    // slave mode
    repeat (4) tick();
    master_i = 1'b0;
    tick();
    write_byte(8'hA7);
    chk("R1 slave write", int'(tx_empty_o), 0);
    tick();
    chk("R2 slave idle reload", int'(tx_empty_o), 1);
    slave_frame(8'h4D, -1, 8'h00, 8'h00, so, txe);
    chk("R2 slave sends loaded", int'(so), 'hA7);
    chk("R7 slave rx", int'(rd_data_o), 'h4D);
    chk("R7 slave rx_full", int'(rx_full_o), 1);
    rd_data();
    chk("R8 data read alone", int'(rx_full_o), 1);
    rd_status(); rd_data();
    chk("R8 two-step clear", int'(rx_full_o), 0);

    slave_frame(8'hE2, 3, 8'h19, 8'h77, so, txe);
    chk("R6 stale resend", int'(so), 'h4D);
    chk("R5 load deferred", int'(txe), 0);
    chk("R5 load at frame end", int'(tx_empty_o), 1);
    rd_status(); rd_data();
    chk("R8 clear again", int'(rx_full_o), 0);
    rd_status();
    slave_frame(8'h61, -1, 8'h00, 8'h00, so, txe);
    chk("R9 ignored write", int'(so), 'h19);
    rd_data();
    chk("R8 early status no arm", int'(rx_full_o), 1);
    chk("R7 slave rx3", int'(rd_data_o), 'h61);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule